// File: doc/BRIEF.md
# Register Pointer Auto-Increment Unit

This block keeps the 8-bit control byte of a serially accessed register file. The upper three bits select an auto-increment mode. The lower five bits are the pointer to the register that the next data byte reads or writes. The bus bit engine reports three kinds of event:

- an acknowledged address phase, with its direction and whether it used the software-reset address;
- a completed data byte;
- a STOP condition.

In a write transaction, the first data byte after the address phase is taken as the new control byte. Each later byte in that transaction steps the pointer. In a read transaction, every byte steps the pointer, starting from the value left by the previous transaction.

Stepping depends on the mode. The pointer can stay fixed, cross the whole map, or circle inside one of three sub-windows: the per-output brightness registers, the two group registers, or both together. A control byte that names a pointer outside the implemented range is flagged so that the engine does not acknowledge it. Such a byte is discarded.

Top module: `regptr_autoinc`

## Requirements
- R1: After reset the control byte reads 80h and the transaction state is idle. Data bytes that arrive before any address phase leave the control byte unchanged.
- R2: After an acknowledged write address that is not the software-reset address, the first data byte whose pointer field (bits 4:0) is 00h..11h is stored whole as the control byte on the clock edge that ends its byte_done pulse.
- R3: If that first byte has a pointer field of 12h..1Fh, `ctrl_nack` is high in the byte_done cycle. The control byte stays unchanged. Later bytes are ignored until the next address phase.
- R4: When bit 7 of the control byte is 0 (mode codes 000, 001, 010, 011), every data byte leaves the control byte unchanged.
- R5: Mode 100 (bits 7:5): the pointer increases by one per byte, and 11h is followed by 00h.
- R6: Mode 101: the pointer increases by one per byte, and 11h is followed by 02h.
- R7: Mode 110: the pointer increases by one below 0Bh. Any pointer at or above 0Bh is followed by 0Ah.
- R8: Mode 111: the pointer increases by one below 0Bh. Any pointer at or above 0Bh is followed by 02h.
- R9: Stepping never changes bits 7:5.
- R10: A read address phase loads nothing. Every read byte steps the pointer from the value left by the previous transaction, including after a repeated START.
- R11: In a transaction opened with the software-reset address, data bytes change nothing.
- R12: If an address phase and a byte_done fall in the same cycle, the address phase wins and the byte is ignored. If a STOP and a byte_done fall in the same cycle, the STOP wins.
- R13: After a STOP, data bytes are ignored until the next address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_hit | input | 1 | One-cycle pulse: address phase acknowledged |
| addr_rw | input | 1 | Direction of that address phase, 1 = read |
| addr_swrst | input | 1 | That address phase used the software-reset address |
| bus_stop | input | 1 | One-cycle pulse: STOP seen on the bus |
| byte_done | input | 1 | One-cycle pulse: a data byte was completed |
| byte_data | input | 8 | Value of the completed byte (meaningful for writes) |
| ctrl_value | output | 8 | Current control byte {mode, pointer} |
| reg_ptr | output | 5 | Current register pointer |
| ctrl_nack | output | 1 | Combinational: the present control byte must not be acknowledged |

## Verification
Two events can collide in one cycle: a byte completion with a new address phase, and a byte completion with a STOP. The bench drives both collisions on purpose, and also lets them occur in its random traffic. Each time, it checks that the control byte keeps its value and that the transaction state follows the winning event. The state is judged by what the next byte does: after a write address that byte must load, and after a STOP it must be ignored. Wraps are checked for every mode, starting both inside and above the mode's window.

// File: rtl/regptr_pkg.sv
package regptr_pkg;

  typedef enum logic [1:0] {
    TXN_IDLE  = 2'd0,
    TXN_CTRL  = 2'd1,
    TXN_DATA  = 2'd2,
    TXN_SWRST = 2'd3
  } txn_t;

  localparam logic [2:0] MODE_ALL   = 3'b100;
  localparam logic [2:0] MODE_IND   = 3'b101;
  localparam logic [2:0] MODE_GRP   = 3'b110;
  localparam logic [2:0] MODE_MIXED = 3'b111;

endpackage

// File: rtl/regptr_txn.sv
module regptr_txn
  import regptr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic addr_hit,
  input  logic addr_rw,
  input  logic addr_swrst,
  input  logic bus_stop,
  input  logic load_evt,
  input  logic nack_evt,
  output txn_t state
);

  txn_t state_nxt;

  always_comb begin
    state_nxt = state;
    if (addr_hit) begin
      if (addr_swrst)   state_nxt = TXN_SWRST;
      else if (addr_rw) state_nxt = TXN_DATA;
      else              state_nxt = TXN_CTRL;
    end else if (bus_stop || nack_evt) begin
      state_nxt = TXN_IDLE;
    end else if (load_evt) begin
      state_nxt = TXN_DATA;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= TXN_IDLE;
    else        state <= state_nxt;
  end

endmodule

// File: rtl/regptr_step.sv
module regptr_step
  import regptr_pkg::*;
#(
  parameter int PTR_W     = 5,
  parameter int LAST_REG  = 17,
  parameter int IND_FIRST = 2,
  parameter int GRP_FIRST = 10,
  parameter int GRP_LAST  = 11
) (
  input  logic [2:0]       mode,
  input  logic [PTR_W-1:0] ptr,
  output logic [PTR_W-1:0] ptr_nxt
);

  localparam logic [PTR_W-1:0] P_LAST  = PTR_W'(LAST_REG);
  localparam logic [PTR_W-1:0] P_IND   = PTR_W'(IND_FIRST);
  localparam logic [PTR_W-1:0] P_GFST  = PTR_W'(GRP_FIRST);
  localparam logic [PTR_W-1:0] P_GLST  = PTR_W'(GRP_LAST);
  localparam logic [PTR_W-1:0] P_ZERO  = '0;

  // Advance inside [lo..hi]; at or past hi jump back to lo.
  function automatic logic [PTR_W-1:0] wrap_inc(
    input logic [PTR_W-1:0] p,
    input logic [PTR_W-1:0] lo,
    input logic [PTR_W-1:0] hi
  );
    if (p >= hi) return lo;
    return p + 1'b1;
  endfunction

  always_comb begin
    unique case (mode)
      MODE_ALL:   ptr_nxt = wrap_inc(ptr, P_ZERO, P_LAST);
      MODE_IND:   ptr_nxt = wrap_inc(ptr, P_IND,  P_LAST);
      MODE_GRP:   ptr_nxt = wrap_inc(ptr, P_GFST, P_GLST);
      MODE_MIXED: ptr_nxt = wrap_inc(ptr, P_IND,  P_GLST);
      default:    ptr_nxt = ptr;
    endcase
  end

endmodule

// File: rtl/regptr_ctrl.sv
module regptr_ctrl #(
  parameter int         AI_W      = 3,
  parameter int         PTR_W     = 5,
  parameter logic [7:0] RESET_VAL = 8'h80
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_evt,
  input  logic                  step_evt,
  input  logic [AI_W+PTR_W-1:0] load_val,
  input  logic [PTR_W-1:0]      ptr_nxt,
  output logic [AI_W+PTR_W-1:0] ctrl_q
);

  localparam int CTRL_W = AI_W + PTR_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ctrl_q <= CTRL_W'(RESET_VAL);
    else if (load_evt) ctrl_q <= load_val;
    else if (step_evt) ctrl_q <= {ctrl_q[CTRL_W-1:PTR_W], ptr_nxt};
  end

endmodule

// File: rtl/regptr_autoinc.sv
module regptr_autoinc
  import regptr_pkg::*;
#(
  parameter int         AI_W      = 3,
  parameter int         PTR_W     = 5,
  parameter int         LAST_REG  = 17,
  parameter int         IND_FIRST = 2,
  parameter int         GRP_FIRST = 10,
  parameter int         GRP_LAST  = 11,
  parameter logic [7:0] RESET_VAL = 8'h80
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  addr_hit,
  input  logic                  addr_rw,
  input  logic                  addr_swrst,
  input  logic                  bus_stop,
  input  logic                  byte_done,
  input  logic [AI_W+PTR_W-1:0] byte_data,
  output logic [AI_W+PTR_W-1:0] ctrl_value,
  output logic [PTR_W-1:0]      reg_ptr,
  output logic                  ctrl_nack
);

  localparam int               CTRL_W = AI_W + PTR_W;
  localparam logic [PTR_W-1:0] P_LAST = PTR_W'(LAST_REG);

  txn_t             txn_state;
  logic             byte_live;
  logic             ptr_bad;
  logic             load_evt;
  logic             step_evt;
  logic             nack_evt;
  logic [PTR_W-1:0] ptr_nxt;

  // Address phase and STOP both outrank a finishing byte.
  assign byte_live = byte_done && !addr_hit && !bus_stop;
  assign ptr_bad   = byte_data[PTR_W-1:0] > P_LAST;
  assign nack_evt  = byte_live && (txn_state == TXN_CTRL) && ptr_bad;
  assign load_evt  = byte_live && (txn_state == TXN_CTRL) && !ptr_bad;
  assign step_evt  = byte_live && (txn_state == TXN_DATA);

  regptr_txn u_txn (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_hit   (addr_hit),
    .addr_rw    (addr_rw),
    .addr_swrst (addr_swrst),
    .bus_stop   (bus_stop),
    .load_evt   (load_evt),
    .nack_evt   (nack_evt),
    .state      (txn_state)
  );

  regptr_step #(
    .PTR_W     (PTR_W),
    .LAST_REG  (LAST_REG),
    .IND_FIRST (IND_FIRST),
    .GRP_FIRST (GRP_FIRST),
    .GRP_LAST  (GRP_LAST)
  ) u_step (
    .mode    (ctrl_value[CTRL_W-1 -: 3]),
    .ptr     (ctrl_value[PTR_W-1:0]),
    .ptr_nxt (ptr_nxt)
  );

  regptr_ctrl #(
    .AI_W      (AI_W),
    .PTR_W     (PTR_W),
    .RESET_VAL (RESET_VAL)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_evt (load_evt),
    .step_evt (step_evt),
    .load_val (byte_data),
    .ptr_nxt  (ptr_nxt),
    .ctrl_q   (ctrl_value)
  );

  assign reg_ptr   = ctrl_value[PTR_W-1:0];
  assign ctrl_nack = nack_evt;

endmodule

// File: rtl/regptr_autoinc_chk.sv
module regptr_autoinc_chk
  import regptr_pkg::*;
#(
  parameter int PTR_W     = 5,
  parameter int CTRL_W    = 8,
  parameter int LAST_REG  = 17,
  parameter int IND_FIRST = 2,
  parameter int GRP_FIRST = 10,
  parameter int GRP_LAST  = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr_hit,
  input logic              bus_stop,
  input logic              byte_done,
  input txn_t              txn_state,
  input logic              step_evt,
  input logic              nack_evt,
  input logic [CTRL_W-1:0] ctrl_value
);

  logic [2:0]       md;
  logic [PTR_W-1:0] pt;
  assign md = ctrl_value[CTRL_W-1 -: 3];
  assign pt = ctrl_value[PTR_W-1:0];

  AST_IDLE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_state == TXN_IDLE && byte_done) |=> $stable(ctrl_value)); // R1
  AST_PTR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    pt <= PTR_W'(LAST_REG)); // R2
  AST_NACK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    nack_evt |=> $stable(ctrl_value)); // R3
  AST_NACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    nack_evt |=> txn_state == TXN_IDLE); // R3
  AST_FIXED_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !md[2]) |=> $stable(ctrl_value)); // R4
  AST_WRAP_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && md == MODE_ALL && pt == PTR_W'(LAST_REG)) |=> pt == '0); // R5
  AST_WRAP_IND: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && md == MODE_IND && pt == PTR_W'(LAST_REG)) |=> pt == PTR_W'(IND_FIRST)); // R6
  AST_WRAP_GRP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && md == MODE_GRP && pt >= PTR_W'(GRP_LAST)) |=> pt == PTR_W'(GRP_FIRST)); // R7
  AST_WRAP_MIX: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && md == MODE_MIXED && pt >= PTR_W'(GRP_LAST)) |=> pt == PTR_W'(IND_FIRST)); // R8
  AST_AI_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> md == $past(md)); // R9
  AST_SWRST_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_state == TXN_SWRST && byte_done) |=> $stable(ctrl_value)); // R11
  AST_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
    ((addr_hit || bus_stop) && byte_done) |=> $stable(ctrl_value)); // R12
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_stop && !addr_hit) |=> txn_state == TXN_IDLE); // R13

endmodule

bind regptr_autoinc regptr_autoinc_chk #(
  .PTR_W     (PTR_W),
  .CTRL_W    (CTRL_W),
  .LAST_REG  (LAST_REG),
  .IND_FIRST (IND_FIRST),
  .GRP_FIRST (GRP_FIRST),
  .GRP_LAST  (GRP_LAST)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr_hit   (addr_hit),
  .bus_stop   (bus_stop),
  .byte_done  (byte_done),
  .txn_state  (txn_state),
  .step_evt   (step_evt),
  .nack_evt   (nack_evt),
  .ctrl_value (ctrl_value)
);

// File: tb/test_regptr_autoinc.sv
`timescale 1ns/1ps
module test_regptr_autoinc;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr_hit = 1'b0, addr_rw = 1'b0, addr_swrst = 1'b0;
  logic       bus_stop = 1'b0, byte_done = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic [7:0] ctrl_value;
  logic [4:0] reg_ptr;
  logic       ctrl_nack;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  // model state: 0 idle, 1 expecting control byte, 2 data, 3 reset-address
  int         m_st;
  logic [7:0] m_ctrl;

  always #2 clk = ~clk;

  regptr_autoinc i_regptr_autoinc (
    .clk(clk), .rst_n(rst_n), .addr_hit(addr_hit), .addr_rw(addr_rw),
    .addr_swrst(addr_swrst), .bus_stop(bus_stop), .byte_done(byte_done),
    .byte_data(byte_data), .ctrl_value(ctrl_value), .reg_ptr(reg_ptr),
    .ctrl_nack(ctrl_nack)
  );

  function automatic logic [7:0] model_step(input logic [7:0] c);
    int lo, hi, p;
    p = int'(c[4:0]);
    if (c[7] == 1'b0) return c;
    case (c[6:5])
      2'b00:   begin lo = 0;  hi = 17; end
      2'b01:   begin lo = 2;  hi = 17; end
      2'b10:   begin lo = 10; hi = 11; end
      default: begin lo = 2;  hi = 11; end
    endcase
    p = (p < hi) ? p + 1 : lo;
    return {c[7:5], 5'(p)};
  endfunction

  function automatic string tag_of(input logic [7:0] c);
    if (!c[7]) return "R4";
    case (c[6:5])
      2'b00: return "R5";
      2'b01: return "R6";
      2'b10: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic do_addr(input logic rw, input logic sw, input logic with_byte,
                         input logic [7:0] d);
    @(negedge clk);
    addr_hit = 1'b1; addr_rw = rw; addr_swrst = sw;
    byte_done = with_byte; byte_data = d;
    @(negedge clk);
    addr_hit = 1'b0; byte_done = 1'b0;
    m_st = sw ? 3 : (rw ? 2 : 1);
    check(with_byte ? "R12" : "R2", ctrl_value, m_ctrl);
  endtask

  task automatic do_stop(input logic with_byte);
    @(negedge clk);
    bus_stop = 1'b1; byte_done = with_byte; byte_data = 8'h84;
    @(negedge clk);
    bus_stop = 1'b0; byte_done = 1'b0;
    m_st = 0;
    check(with_byte ? "R12" : "R13", ctrl_value, m_ctrl);
  endtask

  task automatic do_byte(input logic [7:0] d, input string req);
    logic exp_nack;
    string t;
    @(negedge clk);
    byte_done = 1'b1; byte_data = d;
    exp_nack = (m_st == 1) && (d[4:0] > 5'd17);
    #1;
    check((m_st == 1) ? "R3" : req, {7'd0, ctrl_nack}, {7'd0, exp_nack});
    t = req;
    case (m_st)
      1: if (exp_nack) m_st = 0; else begin m_ctrl = d; m_st = 2; end
      2: begin if (req == "") t = tag_of(m_ctrl); m_ctrl = model_step(m_ctrl); end
      default: ;
    endcase
    if (t == "") t = (m_st == 3) ? "R11" : "R13";
    @(negedge clk);
    byte_done = 1'b0;
    check(t, ctrl_value, m_ctrl);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h1f3a_5c07));
    m_st = 0; m_ctrl = 8'h80;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", ctrl_value, 8'h80);
    check("R1", {3'd0, reg_ptr}, 8'h00);
    do_byte(8'h4c, "R1");                 // idle: ignored

    do_addr(1'b0, 1'b0, 1'b0, 8'h00);
    do_byte(8'hE4, "R2");
    for (int i = 0; i < 9; i++) do_byte(8'h00, "R8");   // 05..0B then 02, 03

    do_addr(1'b0, 1'b0, 1'b0, 8'h00);
    do_byte(8'h91, "R2");
    do_byte(8'h00, "R5");                 // 11h -> 00h under mode 100
    do_byte(8'h00, "R9");

    do_addr(1'b0, 1'b0, 1'b0, 8'h00);
    do_byte(8'hB1, "R2");
    do_byte(8'h00, "R6");                 // -> A2

    do_addr(1'b0, 1'b0, 1'b0, 8'h00);
    do_byte(8'hCC, "R2");
    do_byte(8'h00, "R7");                 // above window -> CA
    do_byte(8'h00, "R7");                 // CB
    do_byte(8'h00, "R7");                 // CA

    do_addr(1'b0, 1'b0, 1'b0, 8'h00);
    do_byte(8'hEF, "R2");
    do_byte(8'h00, "R8");                 // above window -> E2

    do_addr(1'b0, 1'b0, 1'b0, 8'h00);
    do_byte(8'h25, "R2");
    do_byte(8'h77, "R4");
    do_byte(8'h11, "R4");

    do_addr(1'b0, 1'b0, 1'b0, 8'h00);
    do_byte(8'h92, "R3");                 // reserved pointer
    do_byte(8'h83, "R3");                 // ignored afterwards

    do_addr(1'b0, 1'b0, 1'b0, 8'h00);
    do_byte(8'h8F, "R2");
    do_addr(1'b1, 1'b0, 1'b0, 8'h00);     // repeated START, read
    do_byte(8'h55, "R10");
    do_byte(8'h55, "R10");
    do_addr(1'b1, 1'b0, 1'b0, 8'h00);
    do_byte(8'h55, "R10");

    do_addr(1'b0, 1'b1, 1'b0, 8'h00);
    do_byte(8'h06, "R11");
    do_byte(8'h81, "R11");

    do_addr(1'b0, 1'b0, 1'b1, 8'hA3);     // collision: byte ignored
    do_byte(8'hA3, "R12");                // this one loads
    do_stop(1'b1);                        // STOP beats byte
    do_byte(8'h85, "R13");

    for (int i = 0; i < 2000; i++) begin
      int op;
      op = int'($urandom_range(0, 19));
      if (op < 3)       do_addr(1'($urandom_range(0, 2) == 0), 1'($urandom_range(0, 7) == 0),
                                1'($urandom_range(0, 5) == 0), 8'($urandom));
      else if (op < 4)  do_stop(1'($urandom_range(0, 1)));
      else begin
        logic [7:0] d;
        d = 8'($urandom);
        if (m_st == 1 && $urandom_range(0, 3) != 0)
          d[4:0] = 5'($urandom_range(0, 17));
        do_byte(d, "");
      end
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule